// File: doc/BRIEF.md
# Host Frame Mailbox Command and Status Register

This block is an 8-bit register that sits between a host processor and a packet switching core. The host uses it to hand over control frames and data frames to the core and to take them back. It covers one control-frame receive buffer, two control-frame transmit buffers, a receive data FIFO and a transmit data FIFO. The register sits at one address on a simple host bus.

Each bit position has two meanings. A write bit is a one-shot command to the core. The register stores it for a single cycle only, so the core sees a one-cycle pulse. A read bit returns a live ready or status flag. The three buffer-ready flags are held inside the block. The core sets a flag with an input pulse, and the matching host "done" command clears it. The end-of-frame command does not go to the core at once. It arms a pending tag, and the tag marks the next host data write into the receive FIFO as the last word of the frame.

When the interface mode has no frame mailbox (`mbox_en` low), the register reads as zero and every write to it is ignored.

Top module: `cpu_mbox_ctl`

## Requirements
- R1: After reset, a read at the register address (4) returns 0x00 while the core status inputs are low, and all command pulses are low.
- R2: Writing 1 to bit 0 gives `rxb_done_p` high for exactly the one cycle after the write edge and clears receive-buffer-ready (read bit 0). A `rxb_consumed` pulse sets the flag. If both occur in the same cycle, the clear wins.
- R3: Writing 1 to bit 1 (buffer 1) or bit 2 (buffer 2) gives a one-cycle pulse on `txb_done_p[0]` or `txb_done_p[1]` and clears that buffer's ready flag (read bit 1 or bit 2). `txb_load[n]` sets the flag for buffer n+1.
- R4: Writing 1 to bit 3 gives a one-cycle `txf_rxdone_p` pulse. Read bit 3 returns `txf_has_data`.
- R5: Writing 1 to bit 4 arms a pending end-of-frame tag. The next `cpu_fifo_wr` then drives `fifo_wr_last` high in its own cycle, and that write clears the tag. A FIFO write in the same cycle as the arming write is not tagged.
- R6: Writing 1 to bit 5 gives a one-cycle `rxf_realign_p` pulse. Read bit 5 returns `txf_eof`.
- R7: Read bit 4 returns `rxf_has_space`.
- R8: A 0 written to any command bit has no effect. Several command bits set in one write all pulse in the same cycle.
- R9: Bits 7:6 are plain storage. They read back the last value written and have no other effect.
- R10: While `mbox_en` is low, reads return 0x00. Writes then produce no pulses, do not arm the end-of-frame tag and do not change bits 7:6.
- R11: A write at any other address is ignored, and a read at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_en | input | 1 | Interface mode has a frame mailbox |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Host read data (combinational) |
| rxb_consumed | input | 1 | Core has emptied the receive buffer |
| txb_load | input | 2 | Core has filled transmit buffer 2/1 |
| txf_has_data | input | 1 | Transmit FIFO holds data |
| rxf_has_space | input | 1 | Receive FIFO has room |
| txf_eof | input | 1 | Transmit FIFO end of frame |
| cpu_fifo_wr | input | 1 | Host data write into the receive FIFO |
| rxb_done_p | output | 1 | Receive-buffer-written pulse |
| txb_done_p | output | 2 | Transmit-buffer-read pulses |
| txf_rxdone_p | output | 1 | Transmit-FIFO-frame-taken pulse |
| rxf_realign_p | output | 1 | Receive-FIFO realign pulse |
| fifo_wr_last | output | 1 | Current FIFO write is the last of its frame |

## Verification
The assertions assume a synchronous host bus. Address, data and the write strobe are taken as valid at each rising edge, and the core inputs are single-cycle pulses or levels sampled at the same edges. The checks on ready flags and the end-of-frame tag look one cycle back, and they only look when the previous cycle was out of reset. The bench therefore changes every input one time unit after a rising edge and holds all inputs low during reset. It drives `rxb_consumed` and `txb_load` as one-cycle pulses, so each flag change falls on a known edge.

// File: rtl/cpu_mbox_ctl.sv
module cpu_mbox_ctl #(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  input  logic              rxb_consumed,
  input  logic [1:0]        txb_load,
  input  logic              txf_has_data,
  input  logic              rxf_has_space,
  input  logic              txf_eof,
  input  logic              cpu_fifo_wr,
  output logic              rxb_done_p,
  output logic [1:0]        txb_done_p,
  output logic              txf_rxdone_p,
  output logic              rxf_realign_p,
  output logic              fifo_wr_last
);
  localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(REG_ADDR);

  logic       sel, hit;
  logic [4:0] cmd, strobe_q;
  logic       rxb_rdy_q, eof_pend_q;
  logic [1:0] txb_rdy_q, rsv_q;

  assign sel = mbox_en && (bus_addr == ADDR);
  assign hit = sel && bus_wr;
  assign cmd = hit ? {bus_wdata[5], bus_wdata[3:0]} : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q   <= '0;
      rxb_rdy_q  <= 1'b0;
      txb_rdy_q  <= '0;
      eof_pend_q <= 1'b0;
      rsv_q      <= '0;
    end else begin
      strobe_q   <= cmd;
      rxb_rdy_q  <= (rxb_rdy_q | rxb_consumed) & ~cmd[0];
      txb_rdy_q  <= (txb_rdy_q | txb_load) & ~cmd[2:1];
      eof_pend_q <= (hit && bus_wdata[4]) ||
                    (eof_pend_q && !(cpu_fifo_wr && mbox_en));
      if (hit) rsv_q <= bus_wdata[7:6];
    end
  end

  assign rxb_done_p    = strobe_q[0];
  assign txb_done_p    = strobe_q[2:1];
  assign txf_rxdone_p  = strobe_q[3];
  assign rxf_realign_p = strobe_q[4];
  assign fifo_wr_last  = cpu_fifo_wr && mbox_en && eof_pend_q;

  assign rd_data = sel ? {rsv_q, txf_eof, rxf_has_space, txf_has_data, txb_rdy_q, rxb_rdy_q}
                       : 8'h00;
endmodule

module cpu_mbox_ctl_chk #(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        rd_data,
  input logic              rxb_consumed,
  input logic [1:0]        txb_load,
  input logic              rxb_done_p,
  input logic [1:0]        txb_done_p,
  input logic              txf_rxdone_p,
  input logic              rxf_realign_p,
  input logic              rxb_rdy_q,
  input logic [1:0]        txb_rdy_q,
  input logic              eof_pend_q
);
  localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(REG_ADDR);

  AST_RXB_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_done_p |-> $past(bus_wr && mbox_en && bus_addr == ADDR && bus_wdata[0])); // R2
  AST_RXB_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_done_p |-> !rxb_rdy_q); // R2
  AST_RXB_CONSUMED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rxb_consumed) && !rxb_done_p |-> rxb_rdy_q); // R2
  AST_TX1_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(txb_load[0]) && !txb_done_p[0] |-> txb_rdy_q[0]); // R3
  AST_TX2_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(txb_load[1]) && !txb_done_p[1] |-> txb_rdy_q[1]); // R3
  AST_TXF_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    txf_rxdone_p |-> $past(bus_wr && mbox_en && bus_addr == ADDR && bus_wdata[3])); // R4
  AST_EOF_ARM_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(eof_pend_q) |-> $past(bus_wr && mbox_en && bus_addr == ADDR && bus_wdata[4])); // R5
  AST_REALIGN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_realign_p |-> $past(bus_wr && mbox_en && bus_addr == ADDR && bus_wdata[5])); // R6
  AST_DISABLED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(mbox_en) |-> !rxb_done_p && txb_done_p == 2'b00 && !txf_rxdone_p && !rxf_realign_p); // R10
  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |-> rd_data == 8'h00); // R10
endmodule

bind cpu_mbox_ctl cpu_mbox_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_data(rd_data), .rxb_consumed(rxb_consumed), .txb_load(txb_load),
  .rxb_done_p(rxb_done_p), .txb_done_p(txb_done_p), .txf_rxdone_p(txf_rxdone_p),
  .rxf_realign_p(rxf_realign_p), .rxb_rdy_q(rxb_rdy_q), .txb_rdy_q(txb_rdy_q),
  .eof_pend_q(eof_pend_q)
);

// File: tb/sim_cpu_mbox_ctl.sv
`timescale 1ns/1ps
module sim_cpu_mbox_ctl;
  logic clk = 1'b0, rst_n = 1'b0, mbox_en = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rd_data;
  logic rxb_consumed = 1'b0, txf_has_data = 1'b0, rxf_has_space = 1'b0, txf_eof = 1'b0;
  logic [1:0] txb_load = '0, txb_done_p;
  logic cpu_fifo_wr = 1'b0;
  logic rxb_done_p, txf_rxdone_p, rxf_realign_p, fifo_wr_last;
  logic [4:0] strb;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cpu_mbox_ctl u0 (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rxb_consumed(rxb_consumed), .txb_load(txb_load),
    .txf_has_data(txf_has_data), .rxf_has_space(rxf_has_space), .txf_eof(txf_eof),
    .cpu_fifo_wr(cpu_fifo_wr), .rxb_done_p(rxb_done_p), .txb_done_p(txb_done_p),
    .txf_rxdone_p(txf_rxdone_p), .rxf_realign_p(rxf_realign_p), .fifo_wr_last(fifo_wr_last)
  );

  assign strb = {rxf_realign_p, txf_rxdone_p, txb_done_p, rxb_done_p};

  // {write data, expected pulses {realign, txf_rxdone, tx2, tx1, rxb}}
  localparam logic [12:0] VEC [9] = '{
    {8'h01, 5'b00001}, {8'h02, 5'b00010}, {8'h04, 5'b00100}, {8'h08, 5'b01000},
    {8'h20, 5'b10000}, {8'h00, 5'b00000}, {8'h2F, 5'b11111}, {8'hC0, 5'b00000},
    {8'h10, 5'b00000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_addr = 4'd4;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bus_addr = 4'd4;
    repeat (3) step();
    rst_n = 1'b1; mbox_en = 1'b1;
    #1;
    chk("R1 reset read", rd_data, 8'h00);
    chk("R1 reset pulses", {3'b0, strb}, 8'h00);

    for (int i = 0; i < 9; i++) begin
      wr(4'd4, VEC[i][12:5]);
      chk("R8 table pulses", {3'b0, strb}, {3'b0, VEC[i][4:0]});
      step();
      chk("R8 pulse one cycle", {3'b0, strb}, 8'h00);
    end

    chk("R5 armed tag on write", {7'b0, fifo_wr_last}, 8'h00);
    cpu_fifo_wr = 1'b1; #1;
    chk("R5 tagged fifo write", {7'b0, fifo_wr_last}, 8'h01);
    step();
    chk("R5 tag cleared", {7'b0, fifo_wr_last}, 8'h00);
    cpu_fifo_wr = 1'b0;
    bus_addr = 4'd4; bus_wdata = 8'h10; bus_wr = 1'b1; cpu_fifo_wr = 1'b1; #1;
    chk("R5 same cycle untagged", {7'b0, fifo_wr_last}, 8'h00);
    step();
    bus_wr = 1'b0; #1;
    chk("R5 following write tagged", {7'b0, fifo_wr_last}, 8'h01);
    step();
    cpu_fifo_wr = 1'b0;

    rxb_consumed = 1'b1; step(); rxb_consumed = 1'b0;
    chk("R2 consumed sets ready", rd_data, 8'h01);
    wr(4'd4, 8'h01);
    chk("R2 done clears ready", rd_data, 8'h00);
    rxb_consumed = 1'b1; wr(4'd4, 8'h01); rxb_consumed = 1'b0;
    chk("R2 clear wins", rd_data, 8'h00);

    txb_load = 2'b11; step(); txb_load = 2'b00;
    chk("R3 both loaded", rd_data, 8'h06);
    wr(4'd4, 8'h02);
    chk("R3 tx1 done", rd_data, 8'h04);
    wr(4'd4, 8'h04);
    chk("R3 tx2 done", rd_data, 8'h00);

    txf_has_data = 1'b1; #1;
    chk("R4 tx fifo data", rd_data, 8'h08);
    txf_has_data = 1'b0; rxf_has_space = 1'b1; #1;
    chk("R7 rx fifo space", rd_data, 8'h10);
    rxf_has_space = 1'b0; txf_eof = 1'b1; #1;
    chk("R6 tx fifo eof", rd_data, 8'h20);
    txf_eof = 1'b0;

    wr(4'd4, 8'hC0);
    chk("R9 reserved 11", rd_data, 8'hC0);
    wr(4'd4, 8'h40);
    chk("R9 reserved 01", rd_data, 8'h40);

    mbox_en = 1'b0; txf_has_data = 1'b1; #1;
    chk("R10 disabled read", rd_data, 8'h00);
    wr(4'd4, 8'hBF);
    chk("R10 disabled no pulses", {3'b0, strb}, 8'h00);
    step();
    mbox_en = 1'b1; txf_has_data = 1'b0; #1;
    chk("R10 reserved kept", rd_data, 8'h40);
    cpu_fifo_wr = 1'b1; #1;
    chk("R10 eof not armed", {7'b0, fifo_wr_last}, 8'h00);
    step(); cpu_fifo_wr = 1'b0;

    wr(4'd3, 8'hFF);
    chk("R11 other addr no pulses", {3'b0, strb}, 8'h00);
    bus_addr = 4'd3; txf_has_data = 1'b1; #1;
    chk("R11 other addr read", rd_data, 8'h00);
    bus_addr = 4'd4; txf_has_data = 1'b0; #1;
    chk("R11 reserved kept", rd_data, 8'h40);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule